// File: doc/BRIEF.md
# Queue-Depth Priority Memory Crossbar

This block links a set of compute elements to a set of shared single-port memory banks. Each element presents at most one access per cycle. The access names a target bank, a word address, a direction and, for stores, a data word. Alongside it the element reports the live depth of its own input work queue. Accesses aimed at different banks proceed side by side. When several elements aim at the same bank, the bank goes to the element whose queue is deepest, since that element is furthest behind. The ranking is rebuilt every cycle from the depths present in that cycle, so no order between elements is fixed.

Grants are decided combinationally in the cycle the request is shown. A granted store lands in the bank at the end of that cycle. A granted load returns its word on the requester's own read lane one cycle later. A losing element gets no grant. It is expected to keep its request up, and the request simply takes part in the next cycle's contest. When contenders report equal depths, each bank keeps a rotating pointer that picks among them. This lets every tied element win in turn.

Top module: `qdArbXbar`

## Requirements
- R1: Any element can reach either bank. The bank is chosen by that element's bit in `reqBank` (0 selects bank 0, 1 selects bank 1), and the word is chosen by its 8-bit `reqAddr` slice.
- R2: Requests to different banks in the same cycle are all granted in that cycle.
- R3: Each bank grants at most one element per cycle.
- R4: Among the elements requesting one bank, the one with the strictly largest 4-bit `queueDepth` slice is granted.
- R5: Among elements tied at the largest depth for a bank, the grant goes to the first one found scanning upward, with wrap-around, from that bank's pointer. After each grant on a bank, that bank's pointer moves to the winner's index plus one, modulo 4.
- R6: `grant` follows the request inputs in the same cycle without a register. An element with `reqValid` low is never granted.
- R7: A granted store (`reqWrite` high) writes the bank word at the clock edge ending the granted cycle and raises no read return. A granted load raises `rdValid` on that element's lane for exactly the following cycle, with the addressed word on its `rdData` lane.
- R8: A losing element's store leaves the bank unchanged.
- R9: While and after reset, `rdValid` is all low and no grant appears without a request. Reset returns every bank pointer to element 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 4 | Per-element access request |
| reqWrite | input | 4 | Per-element direction, 1 = store |
| reqBank | input | 4 | Per-element target bank index |
| reqAddr | input | 32 | Per-element word address, 8 bits each, element i at [8i+7:8i] |
| reqWdata | input | 64 | Per-element store data, 16 bits each |
| queueDepth | input | 16 | Per-element live queue depth, 4 bits each |
| grant | output | 4 | Per-element grant for the current cycle |
| rdValid | output | 4 | Per-element read return strobe |
| rdData | output | 64 | Per-element read return word, 16 bits each |

## Verification
The hardest behaviour to reach from the ports is the tie rotation. The winner among equal depths depends on a hidden pointer per bank, and that pointer is moved by every earlier grant on the bank, including uncontested ones. The stimulus table therefore runs a long ordered sequence of contests. In it, mixed-depth rounds, single requests and all-equal rounds set each pointer to known positions, and repeated identical all-tie rounds then show the winner walking around the elements. A second reset in the middle of the run, taken while a pointer is known to sit away from element 0, followed by an all-tie round, shows that reset returns the pointer to element 0.

// File: rtl/qdArbPkg.sv
package qdArbPkg;
  localparam int NUM_REQ  = 4;
  localparam int NUM_BANK = 2;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 16;
  localparam int QD_W     = 4;

  localparam int REQ_W  = (NUM_REQ  > 1) ? $clog2(NUM_REQ)  : 1;
  localparam int BANK_W = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1;
  localparam int WORDS  = 1 << ADDR_W;

  // Strobes from arbitration control to the bank datapath.
  typedef struct packed {
    logic [NUM_BANK-1:0]            bankEn;
    logic [NUM_BANK-1:0]            bankWe;
    logic [NUM_BANK-1:0][REQ_W-1:0] bankSel;
  } xbarStrobe_t;
endpackage

// File: rtl/qdArbCtrl.sv
module qdArbCtrl
  import qdArbPkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REQ-1:0]        reqValid,
  input  logic [NUM_REQ-1:0]        reqWrite,
  input  logic [NUM_REQ*BANK_W-1:0] reqBank,
  input  logic [NUM_REQ*QD_W-1:0]   queueDepth,
  output logic [NUM_REQ-1:0]        grant,
  output xbarStrobe_t               strobe
);

  logic [BANK_W-1:0] bankOf  [NUM_REQ];
  logic [QD_W-1:0]   depthOf [NUM_REQ];

  logic [NUM_BANK-1:0]            bankEnV;
  logic [NUM_BANK-1:0]            bankWeV;
  logic [NUM_BANK-1:0][REQ_W-1:0] bankSelV;
  logic [NUM_BANK-1:0][NUM_REQ-1:0] candV;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_unpack
    assign bankOf[i]  = reqBank[i*BANK_W +: BANK_W];
    assign depthOf[i] = queueDepth[i*QD_W +: QD_W];
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic [REQ_W-1:0] ptr;
    logic [REQ_W-1:0] winner;
    logic [REQ_W-1:0] idx;
    logic [QD_W-1:0]  best;
    logic             found;

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_cand
      assign candV[b][i] = reqValid[i] && (bankOf[i] == BANK_W'(b));
    end

    // Scan from the pointer; only a strictly deeper queue displaces the
    // current pick, so the first tied element after the pointer keeps it.
    always_comb begin
      found  = 1'b0;
      winner = ptr;
      best   = '0;
      idx    = '0;
      for (int k = 0; k < NUM_REQ; k++) begin
        idx = REQ_W'((int'(ptr) + k) % NUM_REQ);
        if (candV[b][idx] && (!found || depthOf[idx] > best)) begin
          found  = 1'b1;
          winner = idx;
          best   = depthOf[idx];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ptr <= '0;
      end else if (found) begin
        ptr <= (int'(winner) == NUM_REQ - 1) ? '0 : winner + REQ_W'(1);
      end
    end

    assign bankEnV[b]  = found;
    assign bankSelV[b] = winner;
    assign bankWeV[b]  = reqWrite[winner];
  end

  assign strobe.bankEn  = bankEnV;
  assign strobe.bankWe  = bankWeV;
  assign strobe.bankSel = bankSelV;

  always_comb begin
    grant = '0;
    for (int b = 0; b < NUM_BANK; b++) begin
      for (int i = 0; i < NUM_REQ; i++) begin
        if (bankEnV[b] && (int'(bankSelV[b]) == i)) grant[i] = 1'b1;
      end
    end
  end

  // ---------------- assertions ----------------
  for (genvar b = 0; b < NUM_BANK; b++) begin : g_chkBank
    assert_one_grant_per_bank_R3: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(grant & candV[b]));
    assert_busy_bank_serves_R2: assert property (@(posedge clk) disable iff (!rstN)
      (|candV[b]) |-> (|(grant & candV[b])));
  end

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_chkReq
    assert_grant_needs_request_R6: assert property (@(posedge clk) disable iff (!rstN)
      grant[i] |-> reqValid[i]);
    for (genvar j = 0; j < NUM_REQ; j++) begin : g_pair
      if (i != j) begin : g_diff
        assert_deepest_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
          (grant[i] && reqValid[j] && (bankOf[j] == bankOf[i]))
            |-> (depthOf[j] <= depthOf[i]));
      end
    end
  end

endmodule

// File: rtl/qdArbDatapath.sv
module qdArbDatapath
  import qdArbPkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REQ*ADDR_W-1:0] reqAddr,
  input  logic [NUM_REQ*DATA_W-1:0] reqWdata,
  input  xbarStrobe_t               strobe,
  output logic [NUM_REQ-1:0]        rdValid,
  output logic [NUM_REQ*DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrOf  [NUM_REQ];
  logic [DATA_W-1:0] wdataOf [NUM_REQ];

  logic [NUM_BANK-1:0]              rdPendV;
  logic [NUM_BANK-1:0][REQ_W-1:0]   rdOwnerV;
  logic [NUM_BANK-1:0][DATA_W-1:0]  rdWordV;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_unpack
    assign addrOf[i]  = reqAddr[i*ADDR_W +: ADDR_W];
    assign wdataOf[i] = reqWdata[i*DATA_W +: DATA_W];
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic [DATA_W-1:0] mem [WORDS];
    logic [ADDR_W-1:0] bankAddr;
    logic [DATA_W-1:0] bankWdata;
    logic              doWrite;
    logic              doRead;

    assign bankAddr  = addrOf[strobe.bankSel[b]];
    assign bankWdata = wdataOf[strobe.bankSel[b]];
    assign doWrite   = strobe.bankEn[b] &&  strobe.bankWe[b];
    assign doRead    = strobe.bankEn[b] && !strobe.bankWe[b];

    always_ff @(posedge clk) begin
      if (doWrite) mem[bankAddr] <= bankWdata;
    end

    always_ff @(posedge clk) begin
      if (doRead) rdWordV[b] <= mem[bankAddr];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdPendV[b]  <= 1'b0;
        rdOwnerV[b] <= '0;
      end else begin
        rdPendV[b]  <= doRead;
        if (doRead) rdOwnerV[b] <= strobe.bankSel[b];
      end
    end
  end

  // Return each bank's word on the lane of the element that read it.
  always_comb begin
    rdValid = '0;
    rdData  = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      for (int b = 0; b < NUM_BANK; b++) begin
        if (rdPendV[b] && (int'(rdOwnerV[b]) == i)) begin
          rdValid[i]                 = 1'b1;
          rdData[i*DATA_W +: DATA_W] = rdWordV[b];
        end
      end
    end
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_chk
    assert_return_follows_read_R7: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.bankEn[b] && !strobe.bankWe[b]) |=> rdPendV[b]);
  end

  assert_idle_after_reset_R9: assert property (@(posedge clk)
    $past(!rstN) |-> (rdValid == '0));

endmodule

// File: rtl/qdArbXbar.sv
module qdArbXbar
  import qdArbPkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REQ-1:0]        reqValid,
  input  logic [NUM_REQ-1:0]        reqWrite,
  input  logic [NUM_REQ*BANK_W-1:0] reqBank,
  input  logic [NUM_REQ*ADDR_W-1:0] reqAddr,
  input  logic [NUM_REQ*DATA_W-1:0] reqWdata,
  input  logic [NUM_REQ*QD_W-1:0]   queueDepth,
  output logic [NUM_REQ-1:0]        grant,
  output logic [NUM_REQ-1:0]        rdValid,
  output logic [NUM_REQ*DATA_W-1:0] rdData
);

  xbarStrobe_t strobe;

  qdArbCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqBank    (reqBank),
    .queueDepth (queueDepth),
    .grant      (grant),
    .strobe     (strobe)
  );

  qdArbDatapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .strobe   (strobe),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_chk
    assert_load_returns_next_R7: assert property (@(posedge clk) disable iff (!rstN)
      (grant[i] && !reqWrite[i]) |=> rdValid[i]);
    assert_return_had_load_R7: assert property (@(posedge clk) disable iff (!rstN)
      rdValid[i] |-> $past(grant[i] && !reqWrite[i]));
  end

endmodule

// File: tb/tb_qdArbXbar.sv
`timescale 1ns/1ps
module tb_qdArbXbar;
  import qdArbPkg::*;

  logic                      clk = 1'b0;
  logic                      rstN;
  logic [NUM_REQ-1:0]        reqValid;
  logic [NUM_REQ-1:0]        reqWrite;
  logic [NUM_REQ*BANK_W-1:0] reqBank;
  logic [NUM_REQ*ADDR_W-1:0] reqAddr;
  logic [NUM_REQ*DATA_W-1:0] reqWdata;
  logic [NUM_REQ*QD_W-1:0]   queueDepth;
  logic [NUM_REQ-1:0]        grant;
  logic [NUM_REQ-1:0]        rdValid;
  logic [NUM_REQ*DATA_W-1:0] rdData;

  always #2.5 clk = ~clk;

  qdArbXbar dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBank(reqBank), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .queueDepth(queueDepth), .grant(grant), .rdValid(rdValid), .rdData(rdData)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // {valid[3:0], bank[3:0], depth d3..d0 [15:0], expected grant[3:0]}
  // Pointers start at 0 and are tracked by hand in the comments (R5).
  localparam int NVEC = 12;
  localparam logic [27:0] VEC [NVEC] = '{
    {4'b0000, 4'b0000, 16'h0000, 4'b0000},  // idle                      R6
    {4'b0001, 4'b0000, 16'h0000, 4'b0001},  // lone req0 b0, p0->1       R1
    {4'b1111, 4'b1010, 16'h2753, 4'b0110},  // b0:2 deeper, b1:1 deeper  R2 R4
    {4'b1111, 4'b0000, 16'h9491, 4'b1000},  // tie 1,3 p0=3 -> 3         R5
    {4'b1111, 4'b0000, 16'h9491, 4'b0010},  // p0=0 -> 1                 R5
    {4'b1111, 4'b0000, 16'h9491, 4'b1000},  // p0=2 -> 3                 R5
    {4'b1111, 4'b1111, 16'h4444, 4'b0100},  // b1 all tie p1=2 -> 2      R5
    {4'b1111, 4'b1111, 16'h4444, 4'b1000},  // p1=3 -> 3                 R5
    {4'b1111, 4'b1111, 16'h4444, 4'b0001},  // p1=0 -> 0 (wrap)          R5
    {4'b0101, 4'b0101, 16'h000F, 4'b0001},  // depth 15 vs 0 on b1       R4
    {4'b1010, 4'b1000, 16'h0000, 4'b1010},  // req1 b0, req3 b1          R2
    {4'b1100, 4'b0000, 16'h6600, 4'b0100}   // tie 2,3 p0=2 -> 2         R5
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clearReq();
    reqValid   = '0;
    reqWrite   = '0;
    reqBank    = '0;
    reqAddr    = '0;
    reqWdata   = '0;
    queueDepth = '0;
  endtask

  task automatic setReq(int i, bit wr, int bank, int addr, int data, int depth);
    reqValid[i]                    = 1'b1;
    reqWrite[i]                    = wr;
    reqBank[i*BANK_W +: BANK_W]    = BANK_W'(bank);
    reqAddr[i*ADDR_W +: ADDR_W]    = ADDR_W'(addr);
    reqWdata[i*DATA_W +: DATA_W]   = DATA_W'(data);
    queueDepth[i*QD_W +: QD_W]     = QD_W'(depth);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    rstN = 1'b0;
    clearReq();
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset rdValid", 32'(rdValid), 32'h0);
    check("R9 reset grant", 32'(grant), 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // Vector table: grants decided this cycle, loads return next cycle.
    for (int v = 0; v < NVEC; v++) begin
      logic [27:0] e;
      e = VEC[v];
      @(negedge clk);
      clearReq();
      for (int i = 0; i < NUM_REQ; i++) begin
        if (e[24+i]) setReq(i, 1'b0, int'(e[20+i]), 8'h80 + v, 0, int'(e[4+i*4 +: 4]));
      end
      #1;
      check($sformatf("R4 R5 R6 vec%0d grant", v), 32'(grant), 32'(e[3:0]));
      @(posedge clk);
      #1;
      check($sformatf("R7 vec%0d rdValid", v), 32'(rdValid), 32'(e[3:0]));
    end

    // Parallel stores to both banks, then loads of the same words.
    @(negedge clk);
    clearReq();
    setReq(1, 1'b1, 0, 5, 16'hA5A5, 2);
    setReq(2, 1'b1, 1, 5, 16'h3C3C, 9);
    #1;
    check("R2 parallel store grant", 32'(grant), 32'b0110);
    @(posedge clk);
    #1;
    check("R7 store gives no return", 32'(rdValid), 32'h0);
    @(negedge clk);
    clearReq();
    setReq(0, 1'b0, 0, 5, 0, 1);
    setReq(3, 1'b0, 1, 5, 0, 1);
    #1;
    check("R1 cross loads grant", 32'(grant), 32'b1001);
    @(posedge clk);
    #1;
    check("R7 cross loads rdValid", 32'(rdValid), 32'b1001);
    check("R1 lane0 bank0 word", 32'(rdData[0*DATA_W +: DATA_W]), 32'hA5A5);
    check("R1 lane3 bank1 word", 32'(rdData[3*DATA_W +: DATA_W]), 32'h3C3C);

    // Contending stores to one word: only the deeper queue's store lands.
    @(negedge clk);
    clearReq();
    setReq(0, 1'b1, 0, 9, 16'h1111, 1);
    setReq(1, 1'b1, 0, 9, 16'h2222, 8);
    #1;
    check("R4 store contest grant", 32'(grant), 32'b0010);
    @(negedge clk);
    clearReq();
    setReq(2, 1'b0, 0, 9, 0, 0);
    @(posedge clk);
    #1;
    check("R8 loser store dropped", 32'(rdData[2*DATA_W +: DATA_W]), 32'h2222);
    check("R7 lane2 rdValid", 32'(rdValid), 32'b0100);
    @(negedge clk);
    clearReq();
    @(posedge clk);
    #1;
    check("R7 return lasts one cycle", 32'(rdValid), 32'h0);

    // Bank 0 pointer now sits at 3 (last bank-0 grant was req2); reset it.
    @(negedge clk);
    rstN = 1'b0;
    setReq(0, 1'b0, 0, 1, 0, 3);
    repeat (2) @(posedge clk);
    #1;
    check("R9 rdValid held low in reset", 32'(rdValid), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    clearReq();
    #1;
    check("R9 no grant without request", 32'(grant), 32'h0);
    @(negedge clk);
    for (int i = 0; i < NUM_REQ; i++) setReq(i, 1'b0, 0, i, 0, 7);
    #1;
    check("R9 R5 pointer back at element 0", 32'(grant), 32'b0001);
    @(negedge clk);
    clearReq();
    @(posedge clk);
    #1;
    finish();
  end

endmodule